// File: doc/BRIEF.md
# Shadowed Nonvolatile Register File

This block is the storage and control core that sits behind the serial ports of a nine-pin configurable I/O expander. It presents a 256-entry byte address space to a single bus master. The space holds nonvolatile user bytes, pin configuration registers that keep both a volatile shadow copy and a stored nonvolatile copy, a configuration bit, live pin status and a few bytes of scratch SRAM. The shadow copies of the pin configuration drive nine open-drain pulldown enables and nine pullup enables directly.

Writes that target nonvolatile storage are collected in a single-row buffer of eight bytes. When the master pulses the commit request, the block goes busy for a programmable number of clock cycles that stands in for the cell programming time. At the end of that period it rewrites the whole row: bytes that were written take their new values and the other bytes keep what they held. The nonvolatile cells keep their content across the block reset. When reset is released, a single load cycle copies the stored pin configuration into the shadows, so the pins come up in their stored state. Setting the shadow-only bit makes writes to the pin configuration update the shadow alone, with no stored copy and no busy period.

The control is a four-state machine. ST_LOAD is entered on reset and always moves to ST_IDLE after one cycle. ST_IDLE serves reads and writes and moves to ST_BUSY on a commit request when no access is requested and the row buffer holds at least one byte. ST_BUSY waits for the busy timer and then moves to ST_WRITEBACK. ST_WRITEBACK merges the buffer into the cells, clears the buffer and returns to ST_IDLE after one cycle.

Top module: `nvreg_file`

## Requirements
- R1: Addresses 00h..3Fh read the stored nonvolatile bytes, which are 00h at first power. A write to them changes what a read returns only after a commit has completed.
- R2: Addresses 40h..EFh are reserved. Writes to them change nothing, and reads return 00h.
- R3: F0h bits 7..0 are the pullup enables of pins 7..0, and F1h bit 0 is the pullup enable of pin 8 (1 = enabled). pullup_en[i] equals the stored bit. Both registers default to 00h, and the unused bits of F1h read as 0.
- R4: F2h bits 7..0 control pins 7..0, and F3h bit 0 controls pin 8. A 0 drives the pin low and a 1 releases it, so pulldown_en[i] is the inverse of the control bit. The defaults are FFh and 01h, and the unused bits of F3h read as 0.
- R5: F4h bit 0 is the shadow-only bit (default 0). While it is 1, writes to F0h..F3h update only the shadow, so a commit with nothing else pending starts no busy period. While it is 0, such writes also enter the row buffer. Reads of F4h return the bit in bit 0.
- R6: F5h..F7h are nonvolatile user bytes. F8h returns pin_level[7:0] and F9h returns pin_level[8] in bit 0, with writes to both ignored. FAh..FFh are volatile SRAM that resets to 00h.
- R7: A commit request taken in ST_IDLE with a non-empty buffer raises busy from the next cycle for exactly BUSY_CYCLES cycles. At the end, the written bytes of the buffered row take their new values and the other bytes of that row keep theirs.
- R8: The buffer holds one 8-byte row. A buffered write to a different row discards the bytes pending for the earlier row. A commit request with an empty buffer is ignored.
- R9: While busy, reads, writes and commit requests are ignored and read data returns FFh.
- R10: After reset release, busy is high for one load cycle. The pin shadows then hold their stored nonvolatile copies, which survive reset.
- R11: Read data appears in the cycle after the read request and holds until the next read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; does not clear nonvolatile cells |
| acc_req | input | 1 | Access request, one cycle per byte |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Byte address |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Registered read data |
| commit_req | input | 1 | Pulse to commit the buffered row |
| busy | output | 1 | Load or commit in progress |
| pin_level | input | 9 | Sampled pin levels |
| pulldown_en | output | 9 | Open-drain pulldown enables |
| pullup_en | output | 9 | Pullup enables |

## Verification
The hardest situation to reach is a reset after a commit of the pin configuration rows. Only there does the load cycle put pin states on the outputs that differ from the reset defaults, which proves that the nonvolatile copies survive reset and feed the shadows. The stimulus writes non-default pullup and control values with the shadow-only bit clear, commits, and waits out the busy period. It then sets the shadow-only bit, changes the shadow without storing it, and resets. The restored pin state must match the committed values and not the later shadow writes. A behavioural model that keeps pending writes as a queue is compared with busy, read data and both enable vectors on every clock.

// File: rtl/nvrf_pkg.sv
package nvrf_pkg;
    localparam int BYTE_W      = 8;
    localparam int ROW_BYTES   = 8;
    localparam int LANE_W      = $clog2(ROW_BYTES);
    localparam int USER_BYTES  = 64;
    localparam int USER_ROWS   = USER_BYTES / ROW_BYTES;
    localparam int NV_ROWS     = USER_ROWS + 1;
    localparam int ROW_W       = $clog2(NV_ROWS);
    localparam int PINS        = 9;
    localparam int SRAM_BYTES  = 6;
    localparam int SRAM_W      = $clog2(SRAM_BYTES);

    typedef enum logic [2:0] {
        RG_USER, RG_RSVD, RG_PULLUP, RG_CTRL,
        RG_CONFIG, RG_UPPER_NV, RG_STATUS, RG_SRAM
    } region_e;

    typedef enum logic [1:0] {
        ST_LOAD, ST_IDLE, ST_BUSY, ST_WRITEBACK
    } state_e;

    typedef struct packed {
        region_e            region;
        logic [ROW_W-1:0]   row;
        logic [LANE_W-1:0]  lane;
        logic               nv;
    } decode_t;
endpackage

// File: rtl/nvrf_decode.sv
module nvrf_decode
    import nvrf_pkg::*;
(
    input  logic [BYTE_W-1:0] addr,
    output decode_t           dec
);
    always_comb begin
        dec.lane   = addr[LANE_W-1:0];
        dec.row    = ROW_W'(USER_ROWS);
        dec.nv     = 1'b0;
        dec.region = RG_RSVD;
        if (addr < BYTE_W'(USER_BYTES)) begin
            dec.region = RG_USER;
            dec.row    = ROW_W'(addr[BYTE_W-1:LANE_W]);
            dec.nv     = 1'b1;
        end else if (addr < 8'hF0) begin
            dec.region = RG_RSVD;
        end else if (addr < 8'hF2) begin
            dec.region = RG_PULLUP;
            dec.nv     = 1'b1;
        end else if (addr < 8'hF4) begin
            dec.region = RG_CTRL;
            dec.nv     = 1'b1;
        end else if (addr == 8'hF4) begin
            dec.region = RG_CONFIG;
        end else if (addr < 8'hF8) begin
            dec.region = RG_UPPER_NV;
            dec.nv     = 1'b1;
        end else if (addr < 8'hFA) begin
            dec.region = RG_STATUS;
        end else begin
            dec.region = RG_SRAM;
        end
    end
endmodule

// File: rtl/nvrf_row_buffer.sv
module nvrf_row_buffer
    import nvrf_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             stage_en,
    input  logic [ROW_W-1:0]                 stage_row,
    input  logic [LANE_W-1:0]                stage_lane,
    input  logic [BYTE_W-1:0]                stage_data,
    input  logic                             clear,
    output logic [ROW_W-1:0]                 buf_row,
    output logic [ROW_BYTES-1:0]             buf_mask,
    output logic [ROW_BYTES-1:0][BYTE_W-1:0] buf_data
);
    logic row_switch;

    always_comb row_switch = (buf_mask != '0) && (buf_row != stage_row);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_row  <= '0;
            buf_mask <= '0;
            buf_data <= '0;
        end else if (clear) begin
            buf_mask <= '0;
        end else if (stage_en) begin
            buf_row              <= stage_row;
            buf_data[stage_lane] <= stage_data;
            if (row_switch) buf_mask <= ROW_BYTES'(1) << stage_lane;
            else            buf_mask[stage_lane] <= 1'b1;
        end
    end

    AST_BUF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> buf_mask == '0); // R7
    AST_ROW_SWITCH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_en && !clear && buf_mask != '0 && stage_row != buf_row)
        |=> $countones(buf_mask) == 1); // R8
endmodule

// File: rtl/nvrf_nv_array.sv
module nvrf_nv_array
    import nvrf_pkg::*;
(
    input  logic                             clk,
    input  logic                             wb_en,
    input  logic [ROW_W-1:0]                 wb_row,
    input  logic [ROW_BYTES-1:0]             wb_mask,
    input  logic [ROW_BYTES-1:0][BYTE_W-1:0] wb_data,
    input  logic [ROW_W-1:0]                 rd_row,
    input  logic [LANE_W-1:0]                rd_lane,
    output logic [BYTE_W-1:0]                rd_byte,
    output logic [3:0][BYTE_W-1:0]           pin_image
);
    // Cells are not touched by the block reset; their power-on image is
    // the factory content (control bytes released, everything else zero).
    logic [NV_ROWS-1:0][ROW_BYTES-1:0][BYTE_W-1:0] cells;

    initial begin
        for (int r = 0; r < NV_ROWS; r++)
            for (int l = 0; l < ROW_BYTES; l++)
                cells[r][l] = '0;
        cells[USER_ROWS][2] = 8'hFF;
        cells[USER_ROWS][3] = 8'h01;
    end

    always @(posedge clk) begin
        if (wb_en) begin
            for (int l = 0; l < ROW_BYTES; l++)
                cells[wb_row][l] <= wb_mask[l] ? wb_data[l] : cells[wb_row][l];
        end
    end

    always_comb begin
        rd_byte = cells[rd_row][rd_lane];
        for (int l = 0; l < 4; l++) pin_image[l] = cells[USER_ROWS][l];
    end
endmodule

// File: rtl/nvrf_busy_timer.sv
module nvrf_busy_timer #(
    parameter int CYCLES = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CNT_W = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    localparam int LIM   = CYCLES - 2;

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            run_q <= 1'b1;
            cnt_q <= '0;
        end else if (run_q) begin
            if (cnt_q == CNT_W'(LIM)) run_q <= 1'b0;
            else                      cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb done = run_q && (cnt_q == CNT_W'(LIM));

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> !done); // R7
endmodule

// File: rtl/nvreg_file.sv
module nvreg_file
    import nvrf_pkg::*;
#(
    parameter int BUSY_CYCLES = 1250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_req,
    input  logic              acc_we,
    input  logic [7:0]        acc_addr,
    input  logic [7:0]        acc_wdata,
    output logic [7:0]        acc_rdata,
    input  logic              commit_req,
    output logic              busy,
    input  logic [PINS-1:0]   pin_level,
    output logic [PINS-1:0]   pulldown_en,
    output logic [PINS-1:0]   pullup_en
);
    state_e state_q, state_d;
    decode_t dec;

    logic [PINS-1:0]   pu_q, ctrl_q;
    logic              see_q;
    logic [BYTE_W-1:0] sram_q [SRAM_BYTES];
    logic [SRAM_W-1:0] sram_idx;

    logic acc_ok, wr_ok, load_now, wb_en, stage_en, tmr_start, tmr_done;
    logic [BYTE_W-1:0] stage_data, rd_byte, nv_byte;
    logic [ROW_W-1:0]                 buf_row;
    logic [ROW_BYTES-1:0]             buf_mask;
    logic [ROW_BYTES-1:0][BYTE_W-1:0] buf_data;
    logic [3:0][BYTE_W-1:0]           pin_image;

    nvrf_decode u_dec (.addr(acc_addr), .dec(dec));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD:      state_d = ST_IDLE;
            ST_IDLE:      if (commit_req && !acc_req && buf_mask != '0) state_d = ST_BUSY;
            ST_BUSY:      if (tmr_done) state_d = ST_WRITEBACK;
            ST_WRITEBACK: state_d = ST_IDLE;
        endcase
    end

    // State-derived controls
    always_comb begin
        busy      = (state_q != ST_IDLE);
        load_now  = (state_q == ST_LOAD);
        wb_en     = (state_q == ST_WRITEBACK);
        tmr_start = (state_q == ST_IDLE) && (state_d == ST_BUSY);
        acc_ok    = (state_q == ST_IDLE) && acc_req;
        wr_ok     = acc_ok && acc_we;
        stage_en  = wr_ok && dec.nv &&
                    (!(dec.region inside {RG_PULLUP, RG_CTRL}) || !see_q);
        stage_data = ((dec.region inside {RG_PULLUP, RG_CTRL}) && dec.lane[0])
                   ? {{(BYTE_W-1){1'b0}}, acc_wdata[0]} : acc_wdata;
        sram_idx  = SRAM_W'(acc_addr - 8'hFA);
    end

    nvrf_busy_timer #(.CYCLES(BUSY_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .done(tmr_done));

    nvrf_row_buffer u_buf (
        .clk(clk), .rst_n(rst_n), .stage_en(stage_en), .stage_row(dec.row),
        .stage_lane(dec.lane), .stage_data(stage_data), .clear(wb_en),
        .buf_row(buf_row), .buf_mask(buf_mask), .buf_data(buf_data));

    nvrf_nv_array u_nv (
        .clk(clk), .wb_en(wb_en), .wb_row(buf_row), .wb_mask(buf_mask),
        .wb_data(buf_data), .rd_row(dec.row), .rd_lane(dec.lane),
        .rd_byte(nv_byte), .pin_image(pin_image));

    // Shadow and volatile registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pu_q   <= '0;
            ctrl_q <= '1;
            see_q  <= 1'b0;
            for (int i = 0; i < SRAM_BYTES; i++) sram_q[i] <= '0;
        end else if (load_now) begin
            pu_q   <= {pin_image[1][0], pin_image[0]};
            ctrl_q <= {pin_image[3][0], pin_image[2]};
        end else if (wr_ok) begin
            unique case (dec.region)
                RG_PULLUP: if (dec.lane[0]) pu_q[PINS-1] <= acc_wdata[0];
                           else             pu_q[PINS-2:0] <= acc_wdata;
                RG_CTRL:   if (dec.lane[0]) ctrl_q[PINS-1] <= acc_wdata[0];
                           else             ctrl_q[PINS-2:0] <= acc_wdata;
                RG_CONFIG: see_q <= acc_wdata[0];
                RG_SRAM:   sram_q[sram_idx] <= acc_wdata;
                default:   ;
            endcase
        end
    end

    // Read mux
    always_comb begin
        rd_byte = '0;
        unique case (dec.region)
            RG_USER, RG_UPPER_NV: rd_byte = nv_byte;
            RG_RSVD:   rd_byte = '0;
            RG_PULLUP: rd_byte = dec.lane[0] ? {{(BYTE_W-1){1'b0}}, pu_q[PINS-1]} : pu_q[PINS-2:0];
            RG_CTRL:   rd_byte = dec.lane[0] ? {{(BYTE_W-1){1'b0}}, ctrl_q[PINS-1]} : ctrl_q[PINS-2:0];
            RG_CONFIG: rd_byte = {{(BYTE_W-1){1'b0}}, see_q};
            RG_STATUS: rd_byte = dec.lane[0] ? {{(BYTE_W-1){1'b0}}, pin_level[PINS-1]} : pin_level[PINS-2:0];
            RG_SRAM:   rd_byte = sram_q[sram_idx];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 acc_rdata <= '0;
        else if (acc_req && !acc_we) acc_rdata <= busy ? 8'hFF : rd_byte;
    end

    // Pin drivers
    for (genvar p = 0; p < PINS; p++) begin : g_pin
        assign pulldown_en[p] = ~ctrl_q[p];
        assign pullup_en[p]   = pu_q[p];
    end

    AST_READ_FF_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && !acc_we && busy |=> acc_rdata == 8'hFF); // R9
    AST_SHADOW_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_BUSY |=> $stable(pu_q) && $stable(ctrl_q) && $stable(see_q)); // R9
    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_req && !acc_we) |=> $stable(acc_rdata)); // R11
    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_LOAD |=> state_q == ST_IDLE); // R10
    AST_EMPTY_COMMIT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE && commit_req && !acc_req && buf_mask == '0 |=> !busy); // R8
    AST_COMMIT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE && commit_req && !acc_req && buf_mask != '0 |=> state_q == ST_BUSY); // R7
endmodule

// File: tb/sim_nvreg_file.sv
module sim_nvreg_file;
    localparam int TB_BUSY = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_req = 1'b0, acc_we = 1'b0, commit_req = 1'b0;
    logic [7:0] acc_addr = '0, acc_wdata = '0;
    logic [7:0] acc_rdata;
    logic       busy;
    logic [8:0] pin_level = '0;
    logic [8:0] pulldown_en, pullup_en;

    int n_tests = 0, n_fail = 0;
    bit cmp_on = 0, finished = 0;
    string cur_tag = "R11";

    always #4 clk = ~clk;

    nvreg_file #(.BUSY_CYCLES(TB_BUSY)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_we(acc_we),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .commit_req(commit_req), .busy(busy), .pin_level(pin_level),
        .pulldown_en(pulldown_en), .pullup_en(pullup_en));

    // ---------------- behavioural reference model ----------------
    bit [7:0] m_nv [256];
    bit [7:0] m_vol [256];
    bit [8:0] m_pu, m_ctrl;
    bit       m_see, m_load;
    bit [7:0] m_rdata;
    int       m_left;
    int       q_addr[$];
    bit [7:0] q_data[$];

    initial begin
        for (int a = 0; a < 256; a++) m_nv[a] = 8'h00;
        m_nv[8'hF2] = 8'hFF;
        m_nv[8'hF3] = 8'h01;
    end

    function automatic void m_push(int a, bit [7:0] d);
        if (q_addr.size() > 0 && (q_addr[0] >> 3) != (a >> 3)) begin
            q_addr.delete();
            q_data.delete();
        end
        q_addr.push_back(a);
        q_data.push_back(d);
    endfunction

    function automatic bit [7:0] m_read(int a);
        if (a < 8'h40) return m_nv[a];
        if (a < 8'hF0) return 8'h00;
        case (a)
            8'hF0: return m_pu[7:0];
            8'hF1: return {7'b0, m_pu[8]};
            8'hF2: return m_ctrl[7:0];
            8'hF3: return {7'b0, m_ctrl[8]};
            8'hF4: return {7'b0, m_see};
            8'hF5, 8'hF6, 8'hF7: return m_nv[a];
            8'hF8: return pin_level[7:0];
            8'hF9: return {7'b0, pin_level[8]};
            default: return m_vol[a];
        endcase
    endfunction

    function automatic void m_write(int a, bit [7:0] d);
        if (a < 8'h40 || (a >= 8'hF5 && a <= 8'hF7)) m_push(a, d);
        else if (a == 8'hF0) begin m_pu[7:0] = d; if (!m_see) m_push(a, d); end
        else if (a == 8'hF1) begin m_pu[8] = d[0]; if (!m_see) m_push(a, {7'b0, d[0]}); end
        else if (a == 8'hF2) begin m_ctrl[7:0] = d; if (!m_see) m_push(a, d); end
        else if (a == 8'hF3) begin m_ctrl[8] = d[0]; if (!m_see) m_push(a, {7'b0, d[0]}); end
        else if (a == 8'hF4) m_see = d[0];
        else if (a >= 8'hFA) m_vol[a] = d;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pu = '0; m_ctrl = '1; m_see = 0; m_rdata = 0;
            m_left = 0; m_load = 1;
            for (int a = 0; a < 256; a++) m_vol[a] = 0;
            q_addr.delete(); q_data.delete();
        end else if (m_load || m_left > 0) begin
            if (acc_req && !acc_we) m_rdata = 8'hFF;
            if (m_load) begin
                m_pu   = {m_nv[8'hF1][0], m_nv[8'hF0]};
                m_ctrl = {m_nv[8'hF3][0], m_nv[8'hF2]};
                m_load = 0;
            end else begin
                m_left--;
                if (m_left == 0) begin
                    foreach (q_addr[i]) m_nv[q_addr[i]] = q_data[i];
                    q_addr.delete(); q_data.delete();
                end
            end
        end else if (acc_req) begin
            if (acc_we) m_write(acc_addr, acc_wdata);
            else        m_rdata = m_read(acc_addr);
        end else if (commit_req && q_addr.size() > 0) begin
            m_left = TB_BUSY;
        end
    end

    // ---------------- checking ----------------
    task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !finished) begin
            check("R7 busy", {8'b0, busy}, {8'b0, (m_load || m_left > 0)});
            check("R4 pulldown_en", pulldown_en, ~m_ctrl);
            check("R3 pullup_en", pullup_en, m_pu);
            check({cur_tag, " rdata"}, {1'b0, acc_rdata}, {1'b0, m_rdata});
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); acc_req = 1; acc_we = 1; acc_addr = a; acc_wdata = d;
        @(negedge clk); acc_req = 0; acc_we = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); acc_req = 1; acc_we = 0; acc_addr = a;
        @(negedge clk); acc_req = 0; d = acc_rdata;
    endtask

    task automatic do_commit();
        @(negedge clk); commit_req = 1;
        @(negedge clk); commit_req = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); cmp_on = 0; rst_n = 0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1; cmp_on = 1;
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        cur_tag = "R10";
        do_reset();
        check("R10 busy during load", {8'b0, busy}, 9'd1);
        @(negedge clk);
        check("R10 load done", {8'b0, busy}, 9'd0);
        check("R4 default pulldown", pulldown_en, 9'h000);
        check("R3 default pullup", pullup_en, 9'h000);

        cur_tag = "R1";
        rd(8'h3F, d); check("R1 default 3F", {1'b0, d}, 9'h00);
        wr(8'h05, 8'hA5);
        rd(8'h05, d); check("R1 not visible before commit", {1'b0, d}, 9'h00);
        do_commit(); wait_idle();
        rd(8'h05, d); check("R1 visible after commit", {1'b0, d}, 9'hA5);

        cur_tag = "R7";
        wr(8'h08, 8'h11); wr(8'h0A, 8'h22);
        do_commit();
        check("R7 busy after commit", {8'b0, busy}, 9'd1);
        wait_idle();
        rd(8'h09, d); check("R7 untouched byte", {1'b0, d}, 9'h00);
        rd(8'h0A, d); check("R7 written byte", {1'b0, d}, 9'h22);
        wr(8'h09, 8'h33); do_commit(); wait_idle();
        rd(8'h08, d); check("R7 row kept", {1'b0, d}, 9'h11);

        cur_tag = "R9";
        wr(8'h20, 8'h44); do_commit();
        rd(8'h05, d); check("R9 read during busy", {1'b0, d}, 9'hFF);
        wr(8'h05, 8'h77); wr(8'hF2, 8'h00);
        check("R9 write ignored on pins", pulldown_en, 9'h000);
        wait_idle();
        rd(8'h05, d); check("R9 write ignored", {1'b0, d}, 9'hA5);

        cur_tag = "R8";
        wr(8'h10, 8'h01); wr(8'h18, 8'h02); do_commit(); wait_idle();
        rd(8'h10, d); check("R8 earlier row dropped", {1'b0, d}, 9'h00);
        rd(8'h18, d); check("R8 later row kept", {1'b0, d}, 9'h02);
        do_commit();
        check("R8 empty commit", {8'b0, busy}, 9'd0);

        cur_tag = "R2";
        wr(8'h50, 8'h12); wr(8'hE8, 8'h34);
        rd(8'h50, d); check("R2 reserved 50", {1'b0, d}, 9'h00);
        rd(8'hE8, d); check("R2 reserved E8", {1'b0, d}, 9'h00);

        cur_tag = "R3";
        wr(8'hF0, 8'h5A); wr(8'hF1, 8'hFF); wr(8'hF2, 8'h0F); wr(8'hF3, 8'h00);
        check("R3 pullups", pullup_en, 9'h15A);
        check("R4 pulldowns", pulldown_en, 9'h1F0);
        rd(8'hF1, d); check("R3 F1 unused bits", {1'b0, d}, 9'h01);
        cur_tag = "R4";
        rd(8'hF3, d); check("R4 F3 read", {1'b0, d}, 9'h00);
        do_commit(); wait_idle();

        cur_tag = "R5";
        wr(8'hF4, 8'h01);
        rd(8'hF4, d); check("R5 shadow-only bit", {1'b0, d}, 9'h01);
        wr(8'hF2, 8'hF0); wr(8'hF0, 8'h00);
        check("R5 shadow updated", pulldown_en, 9'h10F);
        do_commit();
        check("R5 no busy in shadow-only", {8'b0, busy}, 9'd0);

        cur_tag = "R10";
        do_reset(); @(negedge clk);
        check("R10 restored pulldowns", pulldown_en, 9'h1F0);
        check("R10 restored pullups", pullup_en, 9'h15A);
        rd(8'hF4, d); check("R10 config reset", {1'b0, d}, 9'h00);
        rd(8'h0A, d); check("R10 nv survives", {1'b0, d}, 9'h22);

        cur_tag = "R6";
        pin_level = 9'h153;
        rd(8'hF8, d); check("R6 pin status low", {1'b0, d}, 9'h53);
        rd(8'hF9, d); check("R6 pin status high", {1'b0, d}, 9'h01);
        wr(8'hF8, 8'h00);
        rd(8'hF8, d); check("R6 status write ignored", {1'b0, d}, 9'h53);
        wr(8'hF6, 8'h9C); do_commit(); wait_idle();
        rd(8'hF6, d); check("R6 upper nv", {1'b0, d}, 9'h9C);
        wr(8'hFA, 8'hC3); wr(8'hFF, 8'h3C);
        rd(8'hFA, d); check("R6 sram FA", {1'b0, d}, 9'hC3);
        cur_tag = "R11";
        rd(8'hFF, d);
        repeat (3) @(negedge clk);
        check("R11 rdata held", {1'b0, acc_rdata}, 9'h03C);
        cur_tag = "R6";
        do_reset(); @(negedge clk);
        rd(8'hFA, d); check("R6 sram reset", {1'b0, d}, 9'h00);

        repeat (2) @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule